// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single read and write requests from an on-chip master into cycles on an external memory bus. Each request runs through three phases. An address phase comes first, with the latch enable high for one clock. A strobe phase follows, with the read or write strobe low for a programmable minimum number of clocks. The strobe phase is stretched while an optional ready input sits at its inactive level. One recovery clock then returns an acknowledge, together with the read data.

The memory side has two 16-bit port buses, each with per-bit output enables, plus the latch enable, the read strobe and the write strobe. Two settings choose how the port buses are used: whether address and data share port 0 (multiplexed) or sit on separate ports (demultiplexed), and whether the data path is 8 or 16 bits wide. The write strobe has two meanings. It can pulse on every write, or it can serve as a low-byte write strobe. The mode, width and write-strobe settings are captured when a request is accepted. The strobe length and ready settings must be held stable while a cycle runs.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: During and after reset, with no request, `ale` is 0, `rdN` and `wrN` are 1, `ack` is 0, and every bit of `p0Oe` and `p1Oe` is 0.
- R2: An accepted request gives exactly one clock with `ale` high. Next come L clocks of strobe phase, then exactly one clock with `ack` high. With ready checking off, L is `cfgStrobeClks`, and a value of 0 counts as 1. `ale` is never high together with a strobe or with `ack`.
- R3: When `cfgRdyEn` is 1, the strobe phase ends at the first clock edge where both conditions hold: at least the minimum number of strobe clocks has passed, and `readyIn` equals `cfgRdyActHigh`. When `cfgRdyEn` is 0, `readyIn` has no effect on L.
- R4: With `cfgWrLow` = 0, `wrN` is low throughout the strobe phase of every write.
- R5: With `cfgWrLow` = 1 on a 16-bit bus (`cfgWide` = 1), `wrN` goes low only for writes with `reqLowLane` = 1. Other writes still run all phases and acknowledge, but `wrN` stays high.
- R6: With `cfgWrLow` = 1 on an 8-bit bus, `wrN` is low throughout the strobe phase of every write, whatever the value of `reqLowLane`.
- R7: In demultiplexed mode (`cfgMuxed` = 0), `p1Out` carries the address with `p1Oe` all ones from the `ale` clock through the `ack` clock. During write strobes, `p0Out[7:0]` carries data bits 7:0. `p0Out[15:8]` carries data bits 15:8 on a 16-bit bus. On an 8-bit bus it is left undriven (`p0Oe[15:8]` = 0). Port 0 is undriven in the `ale` clock.
- R8: In multiplexed mode, port 0 drives the whole address with `p0Oe` all ones in the `ale` clock. In the strobe phase, `p0[7:0]` is the data lane. `p0[15:8]` keeps driving address bits 15:8 on an 8-bit bus, and is the upper data lane on a 16-bit bus.
- R9: While `rdN` is low, the output enables of all data lanes are 0. The `rdData` value shown with `ack` is `p0In` as sampled at the clock edge that ends the strobe. On an 8-bit bus, the upper byte of `rdData` is 0. `rdN` and `wrN` are never both low.
- R10: In multiplexed mode, port 1 is undriven until a demultiplexed cycle has run since reset. After that, multiplexed cycles also drive the address on `p1Out` with `p1Oe` all ones.
- R11: A request is accepted only when no cycle is in progress. A `reqValid` pulse during a running cycle is dropped: no further `ale` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMuxed | input | 1 | 1 = address and data share port 0 |
| cfgWide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| cfgWrLow | input | 1 | 1 = write strobe acts as low-byte write strobe |
| cfgRdyEn | input | 1 | 1 = ready input stretches the strobe phase |
| cfgRdyActHigh | input | 1 | Active level of the ready input |
| cfgStrobeClks | input | 4 | Minimum strobe clocks (0 treated as 1) |
| reqValid | input | 1 | Request pulse, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 16 | Write data |
| reqLowLane | input | 1 | Write includes the low byte |
| ack | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Read data, valid with ack |
| p0Out | output | 16 | Port 0 output value |
| p0Oe | output | 16 | Port 0 output enables |
| p0In | input | 16 | Port 0 pin value |
| p1Out | output | 16 | Port 1 output value |
| p1Oe | output | 16 | Port 1 output enables |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| readyIn | input | 1 | Ready input, programmable level |

## Verification
Two events can fall on the same clock edge: the return of the ready input to its active level, and the expiry of the minimum strobe count. When they coincide, the strobe must end on that edge, with no extra wait clock. The bench provokes this by releasing ready at exactly the clock in which the minimum count runs out, and judges it by counting strobe clocks and checking the `ack` position. A request pulse that lands in the middle of a strobe phase is a second overlap. The bench confirms that this pulse is dropped by watching for any extra `ale` pulse after the acknowledge.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_REC  = 2'd3
  } phase_t;

  // strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic load;     // request accepted this clock
    logic addrPh;   // latch-enable phase
    logic strbPh;   // strobe phase
    logic recPh;    // recovery / acknowledge phase
    logic capture;  // strobe ends at the coming edge
  } busCtl_t;

endpackage

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
  import xmb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             cfgRdyEn,
  input  logic             cfgRdyActHigh,
  input  logic [CNT_W-1:0] cfgStrobeClks,
  input  logic             readyIn,
  output busCtl_t          ctl
);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] stbCnt;
  logic [CNT_W-1:0] minClks;
  logic             minMet;
  logic             rdyOk;
  logic             stbEnd;

  assign minClks = (cfgStrobeClks == '0) ? CNT_W'(1) : cfgStrobeClks;
  assign minMet  = (stbCnt >= minClks);
  assign rdyOk   = !cfgRdyEn || (readyIn == cfgRdyActHigh);
  assign stbEnd  = (phase == PH_STRB) && minMet && rdyOk;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_ADDR;
      PH_ADDR: phaseNext = PH_STRB;
      PH_STRB: if (stbEnd) phaseNext = PH_REC;
      PH_REC:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      stbCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_ADDR) begin
        stbCnt <= CNT_W'(1);
      end else if (phase == PH_STRB && !minMet) begin
        stbCnt <= stbCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctl.load    = (phase == PH_IDLE) && reqValid;
    ctl.addrPh  = (phase == PH_ADDR);
    ctl.strbPh  = (phase == PH_STRB);
    ctl.recPh   = (phase == PH_REC);
    ctl.capture = stbEnd;
  end

endmodule

// File: rtl/xmb_datapath.sv
module xmb_datapath
  import xmb_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  busCtl_t          ctl,
  input  logic             cfgMuxed,
  input  logic             cfgWide,
  input  logic             cfgWrLow,
  input  logic             reqWrite,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqLowLane,
  input  logic [BUS_W-1:0] p0In,
  output logic [BUS_W-1:0] p0Out,
  output logic [BUS_W-1:0] p0Oe,
  output logic [BUS_W-1:0] p1Out,
  output logic [BUS_W-1:0] p1Oe,
  output logic             ale,
  output logic             rdN,
  output logic             wrN,
  output logic             ack,
  output logic [BUS_W-1:0] rdData
);

  localparam int NLANES = BUS_W / LANE_W;

  logic [BUS_W-1:0] addrReg;
  logic [BUS_W-1:0] dataReg;
  logic             wrReg;
  logic             lowLaneReg;
  logic             muxReg;
  logic             wideReg;
  logic             wrLowReg;
  logic             p1Hold;
  logic             inCycle;
  logic             wrAllowed;

  // request and mode capture at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg    <= '0;
      dataReg    <= '0;
      wrReg      <= 1'b0;
      lowLaneReg <= 1'b0;
      muxReg     <= 1'b0;
      wideReg    <= 1'b0;
      wrLowReg   <= 1'b0;
      p1Hold     <= 1'b0;
    end else if (ctl.load) begin
      addrReg    <= reqAddr;
      dataReg    <= reqWdata;
      wrReg      <= reqWrite;
      lowLaneReg <= reqLowLane;
      muxReg     <= cfgMuxed;
      wideReg    <= cfgWide;
      wrLowReg   <= cfgWrLow;
      if (!cfgMuxed) p1Hold <= 1'b1;
    end
  end

  assign inCycle   = ctl.addrPh | ctl.strbPh | ctl.recPh;
  assign wrAllowed = !(wrLowReg && wideReg) || lowLaneReg;

  assign ale = ctl.addrPh;
  assign ack = ctl.recPh;
  assign rdN = !(ctl.strbPh && !wrReg);
  assign wrN = !(ctl.strbPh && wrReg && wrAllowed);

  // port 1: address whenever demultiplexed, or once a demux cycle has run
  assign p1Out = inCycle ? addrReg : '0;
  assign p1Oe  = {BUS_W{inCycle && (!muxReg || p1Hold)}};

  // port 0 lanes
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int  LO       = g * LANE_W;
    localparam bit  LOW_LANE = (g == 0);
    logic              isData;
    logic [LANE_W-1:0] laneOut;
    logic              laneOe;
    logic [LANE_W-1:0] laneRd;

    assign isData = LOW_LANE || wideReg;

    always_comb begin
      laneOut = '0;
      laneOe  = 1'b0;
      if (ctl.addrPh && muxReg) begin
        laneOut = addrReg[LO +: LANE_W];
        laneOe  = 1'b1;
      end else if (ctl.strbPh) begin
        if (isData) begin
          laneOut = dataReg[LO +: LANE_W];
          laneOe  = wrReg;
        end else if (muxReg) begin
          laneOut = addrReg[LO +: LANE_W];
          laneOe  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneRd <= '0;
      end else if (ctl.capture && !wrReg) begin
        laneRd <= isData ? p0In[LO +: LANE_W] : '0;
      end
    end

    assign p0Out[LO +: LANE_W]  = laneOut;
    assign p0Oe[LO +: LANE_W]   = {LANE_W{laneOe}};
    assign rdData[LO +: LANE_W] = laneRd;
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMuxed,
  input  logic             cfgWide,
  input  logic             cfgWrLow,
  input  logic             cfgRdyEn,
  input  logic             cfgRdyActHigh,
  input  logic [CNT_W-1:0] cfgStrobeClks,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqLowLane,
  output logic             ack,
  output logic [BUS_W-1:0] rdData,
  output logic [BUS_W-1:0] p0Out,
  output logic [BUS_W-1:0] p0Oe,
  input  logic [BUS_W-1:0] p0In,
  output logic [BUS_W-1:0] p1Out,
  output logic [BUS_W-1:0] p1Oe,
  output logic             ale,
  output logic             rdN,
  output logic             wrN,
  input  logic             readyIn
);

  localparam int LANE_W = BUS_W / 2;

  busCtl_t ctl;

  xmb_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .cfgRdyEn      (cfgRdyEn),
    .cfgRdyActHigh (cfgRdyActHigh),
    .cfgStrobeClks (cfgStrobeClks),
    .readyIn       (readyIn),
    .ctl           (ctl)
  );

  xmb_datapath #(.BUS_W(BUS_W), .LANE_W(LANE_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgMuxed   (cfgMuxed),
    .cfgWide    (cfgWide),
    .cfgWrLow   (cfgWrLow),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqLowLane (reqLowLane),
    .p0In       (p0In),
    .p0Out      (p0Out),
    .p0Oe       (p0Oe),
    .p1Out      (p1Out),
    .p1Oe       (p1Oe),
    .ale        (ale),
    .rdN        (rdN),
    .wrN        (wrN),
    .ack        (ack),
    .rdData     (rdData)
  );

endmodule

// File: rtl/xmb_chk.sv
module xmb_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ale,
  input logic             rdN,
  input logic             wrN,
  input logic             ack,
  input logic [BUS_W-1:0] p0Oe
);

  localparam int LANE_W = BUS_W / 2;

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && !ack));

  // R2
  rd_end_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> ack);

  // R2
  wr_end_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> ack);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R9
  read_lanes_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (p0Oe[LANE_W-1:0] == '0));

  // R7
  write_lane_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (&p0Oe[LANE_W-1:0]));

endmodule

bind xmem_bus_ctrl xmb_chk #(.BUS_W(BUS_W)) i_xmb_chk (
  .clk  (clk),
  .rstN (rstN),
  .ale  (ale),
  .rdN  (rdN),
  .wrN  (wrN),
  .ack  (ack),
  .p0Oe (p0Oe)
);

// File: tb/test_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module test_xmem_bus_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMuxed = 1'b0, cfgWide = 1'b0, cfgWrLow = 1'b0;
  logic        cfgRdyEn = 1'b0, cfgRdyActHigh = 1'b1;
  logic [3:0]  cfgStrobeClks = 4'd1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqLowLane = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, p0In = '0;
  logic        readyIn = 1'b1;
  logic        ack, ale, rdN, wrN;
  logic [15:0] rdData, p0Out, p0Oe, p1Out, p1Oe;

  int nChk = 0, nFail = 0;

  // observations of the last cycle
  int nAle, nRd, nWr, nCyc, nExtraAle;
  logic [15:0] aleP0Out, aleP0Oe, aleP1Out, aleP1Oe;
  logic [15:0] stbP0Out, stbP0Oe, stbP1Oe, ackP1Oe, gotRd;
  bit done;

  always #4 clk = ~clk;

  xmem_bus_ctrl i_xmem_bus_ctrl (
    .clk(clk), .rstN(rstN), .cfgMuxed(cfgMuxed), .cfgWide(cfgWide),
    .cfgWrLow(cfgWrLow), .cfgRdyEn(cfgRdyEn), .cfgRdyActHigh(cfgRdyActHigh),
    .cfgStrobeClks(cfgStrobeClks), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLowLane(reqLowLane),
    .ack(ack), .rdData(rdData), .p0Out(p0Out), .p0Oe(p0Oe), .p0In(p0In),
    .p1Out(p1Out), .p1Oe(p1Oe), .ale(ale), .rdN(rdN), .wrN(wrN),
    .readyIn(readyIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; readyIn inactive for the first 'holdoff' strobe clocks
  task automatic runCycle(input logic wr, input logic [15:0] addr,
                          input logic [15:0] wdata, input logic lowLane,
                          input logic [15:0] pin, input int holdoff,
                          input bit poke);
    int k;
    nAle = 0; nRd = 0; nWr = 0; nCyc = 0; nExtraAle = 0; k = 0; done = 0;
    aleP0Out = 'x; aleP0Oe = 'x; aleP1Out = 'x; aleP1Oe = 'x;
    stbP0Out = 'x; stbP0Oe = 'x; stbP1Oe = 'x; ackP1Oe = 'x; gotRd = 'x;
    reqWrite = wr; reqAddr = addr; reqWdata = wdata; reqLowLane = lowLane;
    p0In = pin;
    readyIn = (holdoff > 0) ? !cfgRdyActHigh : cfgRdyActHigh;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 80; i++) begin
      nCyc++;
      if (ale) begin
        nAle++;
        aleP0Out = p0Out; aleP0Oe = p0Oe; aleP1Out = p1Out; aleP1Oe = p1Oe;
      end
      if (!rdN) nRd++;
      if (!wrN) nWr++;
      if (!ale && !ack && i > 0) begin
        k++;
        if (k == 1) begin
          stbP0Out = p0Out; stbP0Oe = p0Oe; stbP1Oe = p1Oe;
        end
        readyIn = (k >= holdoff) ? cfgRdyActHigh : !cfgRdyActHigh;
        if (poke) begin
          if (k == 1) begin reqValid = 1'b1; reqAddr = ~addr; end
          if (k == 2) reqValid = 1'b0;
        end
      end
      if (ack) begin
        gotRd = rdData; ackP1Oe = p1Oe; done = 1;
        break;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    readyIn = cfgRdyActHigh;
    repeat (4) begin
      @(negedge clk);
      if (ale) nExtraAle++;
    end
  endtask

  task automatic setCfg(input logic mux, input logic wide, input logic wrl,
                        input logic rdyEn, input logic rdyHi, input logic [3:0] clks);
    cfgMuxed = mux; cfgWide = wide; cfgWrLow = wrl;
    cfgRdyEn = rdyEn; cfgRdyActHigh = rdyHi; cfgStrobeClks = clks;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 rdN/wrN", {rdN, wrN}, 2'b11);
    chk("R1 ack", ack, 0);
    chk("R1 p0Oe", p0Oe, 0);
    chk("R1 p1Oe", p1Oe, 0);
  endtask

  task automatic t_mux8_read();
    setCfg(1, 0, 0, 0, 1, 4'd2);
    runCycle(0, 16'hA53C, 16'h0, 1, 16'h77C4, 0, 0);
    chk("R2 done", done, 1);
    chk("R2 ale count", nAle, 1);
    chk("R2 strobe len", nRd, 2);
    chk("R2 total", nCyc, 4);
    chk("R8 ale p0Out", aleP0Out, 16'hA53C);
    chk("R8 ale p0Oe", aleP0Oe, 16'hFFFF);
    chk("R10 no p1 before demux", aleP1Oe, 16'h0000);
    chk("R8 stb hi addr", stbP0Out[15:8], 8'hA5);
    chk("R9 stb p0Oe", stbP0Oe, 16'hFF00);
    chk("R9 rdData 8-bit", gotRd, 16'h00C4);
  endtask

  task automatic t_mux16_write();
    setCfg(1, 1, 0, 0, 1, 4'd3);
    runCycle(1, 16'h1234, 16'hBEEF, 1, 16'h0, 0, 0);
    chk("R8 ale p0Out", aleP0Out, 16'h1234);
    chk("R8 stb p0Out", stbP0Out, 16'hBEEF);
    chk("R8 stb p0Oe", stbP0Oe, 16'hFFFF);
    chk("R4 wr len", nWr, 3);
    chk("R4 no rd", nRd, 0);
    chk("R2 total", nCyc, 5);
    // zero strobe setting counts as one
    setCfg(1, 1, 0, 0, 1, 4'd0);
    runCycle(1, 16'h0F0F, 16'h1111, 0, 16'h0, 0, 0);
    chk("R2 zero clks", nWr, 1);
    chk("R4 wr on high-only write", nWr, 1);
  endtask

  task automatic t_wrl16();
    setCfg(1, 1, 1, 0, 1, 4'd2);
    runCycle(1, 16'h2000, 16'hAB00, 0, 16'h0, 0, 0);
    chk("R5 no wr high-only", nWr, 0);
    chk("R5 still acks", done, 1);
    chk("R5 total", nCyc, 4);
    runCycle(1, 16'h2001, 16'h00CD, 1, 16'h0, 0, 0);
    chk("R5 wr low lane", nWr, 2);
  endtask

  task automatic t_wrl8();
    setCfg(1, 0, 1, 0, 1, 4'd3);
    runCycle(1, 16'h3003, 16'h0055, 0, 16'h0, 0, 0);
    chk("R6 wr 8-bit", nWr, 3);
    chk("R8 stb hi addr on write", stbP0Out, 16'h3055);
  endtask

  task automatic t_ready();
    setCfg(1, 1, 0, 1, 0, 4'd2);
    runCycle(0, 16'h4444, 16'h0, 1, 16'h9A9B, 5, 0);
    chk("R3 stretched", nRd, 5);
    chk("R3 total", nCyc, 7);
    chk("R3 rdData", gotRd, 16'h9A9B);
    setCfg(1, 1, 0, 1, 1, 4'd3);
    runCycle(0, 16'h4445, 16'h0, 1, 16'h1357, 3, 0);
    chk("R3 release at min", nRd, 3);
    runCycle(1, 16'h4446, 16'h2468, 1, 16'h0, 1, 0);
    chk("R3 active-high no wait", nWr, 3);
    setCfg(1, 1, 0, 0, 1, 4'd2);
    runCycle(0, 16'h4447, 16'h0, 1, 16'h5555, 6, 0);
    chk("R3 ignored when off", nRd, 2);
  endtask

  task automatic t_demux();
    setCfg(0, 1, 0, 0, 1, 4'd2);
    runCycle(0, 16'hC0DE, 16'h0, 1, 16'hFACE, 0, 0);
    chk("R7 ale p1Out", aleP1Out, 16'hC0DE);
    chk("R7 ale p1Oe", aleP1Oe, 16'hFFFF);
    chk("R7 ale p0 undriven", aleP0Oe, 16'h0000);
    chk("R7 stb p1Oe", stbP1Oe, 16'hFFFF);
    chk("R7 ack p1Oe", ackP1Oe, 16'hFFFF);
    chk("R9 stb p0Oe", stbP0Oe, 16'h0000);
    chk("R9 rdData 16-bit", gotRd, 16'hFACE);
    setCfg(0, 0, 0, 0, 1, 4'd1);
    runCycle(1, 16'hD00D, 16'h6789, 1, 16'h0, 0, 0);
    chk("R7 8-bit p0Oe", stbP0Oe, 16'h00FF);
    chk("R7 8-bit p0 low", stbP0Out[7:0], 8'h89);
    chk("R4 wr demux", nWr, 1);
  endtask

  task automatic t_switch();
    setCfg(1, 1, 0, 0, 1, 4'd1);
    runCycle(0, 16'h7E57, 16'h0, 1, 16'h0, 0, 0);
    chk("R10 p1Oe after switch", aleP1Oe, 16'hFFFF);
    chk("R10 p1Out after switch", aleP1Out, 16'h7E57);
    chk("R8 mux p0 still address", aleP0Out, 16'h7E57);
  endtask

  task automatic t_busy();
    setCfg(1, 1, 0, 0, 1, 4'd3);
    runCycle(0, 16'h8888, 16'h0, 1, 16'h0101, 0, 1);
    chk("R11 one ale", nAle, 1);
    chk("R11 no extra cycle", nExtraAle, 0);
    chk("R11 rdData", gotRd, 16'h0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_mux8_read();
    t_mux16_write();
    t_wrl16();
    t_wrl8();
    t_ready();
    t_demux();
    t_switch();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule